// File: doc/BRIEF.md
# Multi-cycle 8-bit processor core

A compact accumulator-free processor core with four general registers, an 8-bit program counter and a 256-byte internal memory. Each instruction is carried out as a sequence of single-clock register transfers under a state machine. The memory address register and memory buffer register are the only route to memory. A four-way BUS selects one of four sources: the shifter output, the ALU output, the program counter or the buffer register. Two hidden operand latches (A, B) feed the ALU and shifter. There is no direct BUS path from the general registers or from memory data.

The memory image at reset comes from a parameter. Software-visible state is exposed only through debug outputs. `dbg_fetch` marks the first cycle of every instruction, and all architectural state shown at that point is the result of the previous instruction. Instruction classes are two-address register operations, one-address register operations, a return, two-byte memory-reference instructions with a selectable number of dereference levels, conditional two-word skips and a no-operation group.

Top module: `mc8_core`

## Requirements
- R1: Every instruction starts with a three-cycle fetch. The first fetch cycle copies PC into the address register. The second reads memory into the buffer register and adds one to PC. The third moves the buffer into IR. `dbg_fetch` is high exactly in the first fetch cycle.
- R2: A byte `0ooo ddss` is a two-address operation on registers (field 00=R0, 01=R1, 10=R2, 11=R3, for dd, ss and every rr below). Opcodes are 000 copy ss to dd, 001 dd+ss, 010 dd+ss+carry, 011 dd−ss, 100 compare, 101 AND, 110 OR and 111 XOR. The result goes to dd. The instruction takes 5 cycles.
- R3: After a two- or one-address operation, the negative flag equals bit 7 of the result. For a two-address operation, carry is the carry-out for 001/010. It is the borrow (dd<ss) for 011/100, and it is cleared for 000, 101, 110 and 111. Compare updates the flags as subtract does but leaves every register unchanged.
- R4: A byte `100o oorr` is a one-address operation on rr, taking 5 cycles. Opcodes are 000 increment (carry when input was FF) and 001 decrement (carry when input was 00). Next come 010 clear, 011 complement (both clear carry) and 100 arithmetic right shift. Then 101 logical right shift (both put old bit 0 in carry) and 110 left shift (old bit 7 to carry). Last is 111 rotate left through carry: old carry enters bit 0 and old bit 7 goes to carry.
- R5: A byte `1010 0xrr` loads PC from rr, leaves flags and registers unchanged, and takes 5 cycles.
- R6: A byte `11kk mmrr` is a two-byte memory instruction (kk: 00 load, 01 store, 10 jump, 11 call), where mm is the number of dereferences applied to the second byte. None of them changes the flags. Load puts the second byte itself (mm=0) or the byte reached after mm reads into rr, and takes 6+2·mm cycles.
- R7: Store writes rr to memory and resumes after the second byte. For mm=0 it writes the second byte's own location, taking 5 cycles. For mm≥1 it writes the address reached by mm−1 dereferences of the second byte, taking 5+2·mm cycles.
- R8: Jump loads PC with the second byte (mm=0) or with the byte reached after mm reads, taking 6+2·mm cycles.
- R9: Call writes the return address (the address after the second byte) into rr, then jumps as R8 does, taking 7+2·mm cycles.
- R10: A byte `1010 1xcc` is a skip, where cc is 00 always, 01 carry set, 10 carry clear and 11 negative set. A true condition adds two to PC in two steps (5 cycles total). A false one leaves PC at the next byte (4 cycles).
- R11: A byte `1011 xxxx` changes no register, flag or memory and takes 3 cycles.
- R12: Reset clears PC, IR, all registers and both flags, loads memory from the image parameter (byte i at bits 8i+7:8i) and starts in the first fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_pc | output | 8 | Program counter |
| dbg_ir | output | 8 | Instruction register |
| dbg_regs | output | 32 | R0 in bits 7:0 up to R3 in bits 31:24 |
| dbg_carry | output | 1 | Carry flag |
| dbg_neg | output | 1 | Negative flag |
| dbg_fetch | output | 1 | High in the first fetch cycle of each instruction |

## Verification
A wrong internal state appears first in the timing of `dbg_fetch`. A mis-sequenced state machine, a wrong dereference count or a skipped fetch step moves the next instruction boundary by at least one cycle, and this is caught within the instruction where it occurs. Wrong data paths or flag rules show up in the register, PC and flag outputs at the very next boundary. A bad store stays hidden until a later load or a return through the damaged value brings it back to a register. The test program therefore loads every stored location again before it ends.

// File: rtl/mc8_pkg.sv
package mc8_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NREG = 4;
  localparam int RW   = $clog2(NREG);

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_X1, S_X2, S_MR1, S_MR2, S_CS,
    S_IND1, S_IND2, S_LDF, S_JF, S_STW, S_SK1, S_SK2
  } state_t;

  typedef enum logic [1:0] {BUS_SH, BUS_ALU, BUS_PC, BUS_MBR} bus_sel_t;

  typedef enum logic [1:0] {MK_LOAD, MK_STORE, MK_JUMP, MK_CALL} mkind_t;

  typedef struct packed {
    logic     mar_ld;
    logic     mbr_ld;
    logic     pc_inc;
    logic     pc_ld;
    logic     ir_ld;
    logic     ab_ld;
    logic     reg_we;
    logic     flag_we;
    logic     mem_we;
    bus_sel_t bus_sel;
  } ctl_t;

  localparam logic [3:0] OP_CMP = 4'h4;

  function automatic logic is_two(input logic [DW-1:0] ins);
    return ~ins[7];
  endfunction
  function automatic logic is_one(input logic [DW-1:0] ins);
    return ins[7:5] == 3'b100;
  endfunction
  function automatic logic is_ret(input logic [DW-1:0] ins);
    return ins[7:3] == 5'b10100;
  endfunction
  function automatic logic is_skip(input logic [DW-1:0] ins);
    return ins[7:3] == 5'b10101;
  endfunction
  function automatic logic is_mem(input logic [DW-1:0] ins);
    return ins[7:6] == 2'b11;
  endfunction

  // unified operation code: two-address ops 0..7, one-address ops 8..15
  function automatic logic [3:0] exec_op(input logic [DW-1:0] ins);
    return ins[7] ? {1'b1, ins[4:2]} : {1'b0, ins[6:4]};
  endfunction

  // returns {carry, result}
  function automatic logic [DW:0] alu_fn(input logic [3:0] op,
                                        input logic [DW-1:0] a,
                                        input logic [DW-1:0] b,
                                        input logic cin);
    logic [DW:0] ea, eb, one, ec;
    ea  = {1'b0, a};
    eb  = {1'b0, b};
    one = {{DW{1'b0}}, 1'b1};
    ec  = {{DW{1'b0}}, cin};
    case (op)
      4'h0:       return eb;
      4'h1:       return ea + eb;
      4'h2:       return ea + eb + ec;
      4'h3, 4'h4: return ea - eb;
      4'h5:       return {1'b0, a & b};
      4'h6:       return {1'b0, a | b};
      4'h7:       return {1'b0, a ^ b};
      4'h8:       return ea + one;
      4'h9:       return ea - one;
      4'hA:       return '0;
      4'hB:       return {1'b0, ~a};
      default:    return ea;
    endcase
  endfunction

  // returns {carry, result}; pass gives A unchanged
  function automatic logic [DW:0] sh_fn(input logic [1:0] kind,
                                       input logic pass,
                                       input logic [DW-1:0] a,
                                       input logic cin);
    if (pass) return {1'b0, a};
    case (kind)
      2'd0:    return {a[0], a[DW-1], a[DW-1:1]};
      2'd1:    return {a[0], 1'b0, a[DW-1:1]};
      2'd2:    return {a[DW-1], a[DW-2:0], 1'b0};
      default: return {a[DW-1], a[DW-2:0], cin};
    endcase
  endfunction

  function automatic logic skip_true(input logic [1:0] cc, input logic c,
                                     input logic n);
    case (cc)
      2'd0:    return 1'b1;
      2'd1:    return c;
      2'd2:    return ~c;
      default: return n;
    endcase
  endfunction
endpackage

// File: rtl/mc8_alu.sv
module mc8_alu
  import mc8_pkg::*;
(
  input  logic [3:0]    op,
  input  logic [1:0]    sh_kind,
  input  logic          sh_pass,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] alu_out,
  output logic          alu_c,
  output logic [DW-1:0] sh_out,
  output logic          sh_c
);
  logic [DW:0] alu_w, sh_w;

  always_comb begin
    alu_w = alu_fn(op, a, b, cin);
    sh_w  = sh_fn(sh_kind, sh_pass, a, cin);
  end

  assign alu_out = alu_w[DW-1:0];
  assign alu_c   = alu_w[DW];
  assign sh_out  = sh_w[DW-1:0];
  assign sh_c    = sh_w[DW];
endmodule

// File: rtl/mc8_regfile.sv
module mc8_regfile
  import mc8_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RW-1:0]      wsel,
  input  logic [DW-1:0]      wdata,
  input  logic [RW-1:0]      rsel_a,
  input  logic [RW-1:0]      rsel_b,
  output logic [DW-1:0]      rdata_a,
  output logic [DW-1:0]      rdata_b,
  output logic [NREG*DW-1:0] flat
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs[g] <= '0;
      else if (we && wsel == RW'(g))        regs[g] <= wdata;
    end
    assign flat[g*DW +: DW] = regs[g];
  end

  assign rdata_a = regs[rsel_a];
  assign rdata_b = regs[rsel_b];
endmodule

// File: rtl/mc8_mem.sv
module mc8_mem
  import mc8_pkg::*;
#(
  parameter int                     DEPTH = 2**AW,
  parameter logic [DEPTH*DW-1:0]    INIT  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= INIT[i*DW +: DW];
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];

  // a write is visible at the same address one cycle later
  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (addr != $past(addr)) || (rdata == $past(wdata)));
endmodule

// File: rtl/mc8_ctrl.sv
module mc8_ctrl
  import mc8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mbr,
  input  logic [DW-1:0] ir,
  input  logic          carry,
  input  logic          neg,
  output state_t        state,
  output ctl_t          ctl
);
  state_t    nxt;
  logic [1:0] cnt, cnt_nxt;
  mkind_t    kind;
  logic [1:0] mode;
  state_t    fin;
  logic      is_store;

  assign kind     = mkind_t'(ir[5:4]);
  assign mode     = ir[3:2];
  assign is_store = (kind == MK_STORE);
  assign fin      = (kind == MK_LOAD) ? S_LDF : S_JF;

  always_comb begin
    ctl     = '0;
    nxt     = S_F1;
    cnt_nxt = cnt;
    case (state)
      S_F1: begin
        ctl.bus_sel = BUS_PC;
        ctl.mar_ld  = 1'b1;
        nxt         = S_F2;
      end
      S_F2: begin
        ctl.mbr_ld = 1'b1;
        ctl.pc_inc = 1'b1;
        nxt        = S_F3;
      end
      S_F3: begin
        ctl.ir_ld = 1'b1;
        if (is_two(mbr) || is_one(mbr) || is_ret(mbr)) nxt = S_X1;
        else if (is_skip(mbr))                         nxt = S_SK1;
        else if (is_mem(mbr))                          nxt = S_MR1;
        else                                           nxt = S_F1;
      end
      S_X1: begin
        ctl.ab_ld = 1'b1;
        nxt       = S_X2;
      end
      S_X2: begin
        if (is_ret(ir)) begin
          ctl.bus_sel = BUS_SH;
          ctl.pc_ld   = 1'b1;
        end else begin
          ctl.bus_sel = (is_one(ir) && ir[4]) ? BUS_SH : BUS_ALU;
          ctl.flag_we = 1'b1;
          ctl.reg_we  = ~(is_two(ir) && exec_op(ir) == OP_CMP);
        end
      end
      S_MR1: begin
        ctl.bus_sel = BUS_PC;
        ctl.mar_ld  = 1'b1;
        ctl.ab_ld   = 1'b1;
        nxt         = (is_store && mode == 2'd0) ? S_STW : S_MR2;
      end
      S_MR2: begin
        ctl.mbr_ld = 1'b1;
        ctl.pc_inc = 1'b1;
        cnt_nxt    = mode;
        if (kind == MK_CALL)   nxt = S_CS;
        else if (mode == 2'd0) nxt = fin;
        else                   nxt = S_IND1;
      end
      S_CS: begin
        ctl.bus_sel = BUS_PC;
        ctl.reg_we  = 1'b1;
        nxt         = (cnt == 2'd0) ? S_JF : S_IND1;
      end
      S_IND1: begin
        ctl.bus_sel = BUS_MBR;
        ctl.mar_ld  = 1'b1;
        nxt         = (is_store && cnt == 2'd1) ? S_STW : S_IND2;
      end
      S_IND2: begin
        ctl.mbr_ld = 1'b1;
        cnt_nxt    = cnt - 2'd1;
        nxt        = (!is_store && cnt == 2'd1) ? fin : S_IND1;
      end
      S_LDF: begin
        ctl.bus_sel = BUS_MBR;
        ctl.reg_we  = 1'b1;
      end
      S_JF: begin
        ctl.bus_sel = BUS_MBR;
        ctl.pc_ld   = 1'b1;
      end
      S_STW: begin
        ctl.bus_sel = BUS_SH;
        ctl.mem_we  = 1'b1;
        ctl.pc_inc  = (mode == 2'd0);
      end
      S_SK1: begin
        if (skip_true(ir[1:0], carry, neg)) begin
          ctl.pc_inc = 1'b1;
          nxt        = S_SK2;
        end
      end
      S_SK2: ctl.pc_inc = 1'b1;
      default: nxt = S_F1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_F1;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end

  a_r1_f1_then_f2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_F1 |=> state == S_F2);
  a_r1_f2_then_f3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_F2 |=> state == S_F3);
  a_r10_skip_ends: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SK2 |=> state == S_F1);
endmodule

// File: rtl/mc8_core.sv
module mc8_core
  import mc8_pkg::*;
#(
  parameter int                        MEM_DEPTH = 2**AW,
  parameter logic [MEM_DEPTH*DW-1:0]   MEM_INIT  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [DW-1:0]      dbg_pc,
  output logic [DW-1:0]      dbg_ir,
  output logic [NREG*DW-1:0] dbg_regs,
  output logic               dbg_carry,
  output logic               dbg_neg,
  output logic               dbg_fetch
);
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mbr, ir, a_q, b_q, bus, mem_q;
  logic          c_q, n_q;
  state_t        state;
  ctl_t          ctl;

  logic [DW-1:0] rd_a, rd_b, alu_out, sh_out;
  logic          alu_c, sh_c, use_sh;
  logic [RW-1:0] sel_a;

  // named internal events for checking
  logic          ev_cmp_exec, ev_ret_exec;

  mc8_ctrl u_ctrl (
    .clk, .rst_n, .mbr, .ir, .carry(c_q), .neg(n_q), .state, .ctl
  );

  assign sel_a  = is_two(ir) ? ir[3:2] : ir[1:0];
  assign use_sh = is_one(ir) && ir[4];

  mc8_regfile u_rf (
    .clk, .rst_n,
    .we(ctl.reg_we), .wsel(sel_a), .wdata(bus),
    .rsel_a(sel_a), .rsel_b(ir[1:0]),
    .rdata_a(rd_a), .rdata_b(rd_b), .flat(dbg_regs)
  );

  mc8_alu u_alu (
    .op(exec_op(ir)), .sh_kind(ir[3:2]), .sh_pass(~use_sh),
    .a(a_q), .b(b_q), .cin(c_q),
    .alu_out, .alu_c, .sh_out, .sh_c
  );

  mc8_mem #(.DEPTH(MEM_DEPTH), .INIT(MEM_INIT)) u_mem (
    .clk, .rst_n, .we(ctl.mem_we), .addr(mar), .wdata(bus), .rdata(mem_q)
  );

  always_comb begin
    case (ctl.bus_sel)
      BUS_SH:  bus = sh_out;
      BUS_ALU: bus = alu_out;
      BUS_PC:  bus = pc;
      default: bus = mbr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      if (ctl.pc_ld)       pc <= bus;
      else if (ctl.pc_inc) pc <= pc + AW'(1);
      if (ctl.mar_ld)  mar <= bus;
      if (ctl.mbr_ld)  mbr <= mem_q;
      if (ctl.ir_ld)   ir  <= mbr;
      if (ctl.ab_ld) begin
        a_q <= rd_a;
        b_q <= rd_b;
      end
      if (ctl.flag_we) begin
        c_q <= use_sh ? sh_c : alu_c;
        n_q <= bus[DW-1];
      end
    end
  end

  assign dbg_pc    = pc;
  assign dbg_ir    = ir;
  assign dbg_carry = c_q;
  assign dbg_neg   = n_q;
  assign dbg_fetch = (state == S_F1);

  assign ev_cmp_exec = (state == S_X2) && is_two(ir) && exec_op(ir) == OP_CMP;
  assign ev_ret_exec = (state == S_X2) && is_ret(ir);

  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_F2 |=> pc == $past(pc) + AW'(1));
  a_r3_cmp_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp_exec |=> $stable(dbg_regs));
  a_r5_return_pc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ret_exec |=> pc == $past(a_q));
  a_r10_skip_two: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SK2 |=> pc == $past(pc, 2) + AW'(2));
endmodule

// File: tb/mc8_core_tb.sv
`timescale 1ns/1ps
module mc8_core_tb;
  localparam int NINSTR = 60;

  localparam logic [8*53-1:0] SEQ = {
    8'hC0, 8'h37, 8'hC1, 8'hC9, 8'hC6, 8'hF0, 8'hCB, 8'hF1, 8'h11, 8'h25,
    8'hA9, 8'hE0, 8'hFF, 8'h3B, 8'hA9, 8'h44, 8'hAB, 8'hE0, 8'hFF, 8'hAA,
    8'hE0, 8'hFF, 8'h57, 8'h6D, 8'h79, 8'h01, 8'h80, 8'h86, 8'h8A, 8'h86,
    8'h82, 8'h8F, 8'h93, 8'h97, 8'h9B, 8'h9F, 8'h9F, 8'hD3, 8'h00, 8'hD4,
    8'hF3, 8'hDA, 8'hF1, 8'hC5, 8'h26, 8'hC6, 8'hF3, 8'hCB, 8'hF1, 8'hF0,
    8'h40, 8'hE4, 8'hF4};

  function automatic logic [2047:0] build_image();
    logic [2047:0] p;
    p = '0;
    for (int i = 0; i < 53; i++) p[8*i +: 8] = SEQ[8*(52-i) +: 8];
    p[8*8'h40 +: 8] = 8'h81; p[8*8'h41 +: 8] = 8'hA0;
    p[8*8'h50 +: 8] = 8'hB0; p[8*8'h51 +: 8] = 8'hFB; p[8*8'h52 +: 8] = 8'hF6;
    p[8*8'h53 +: 8] = 8'hE0; p[8*8'h54 +: 8] = 8'h53;
    p[8*8'h60 +: 8] = 8'hA8; p[8*8'h61 +: 8] = 8'hE0; p[8*8'h62 +: 8] = 8'hFF;
    p[8*8'h63 +: 8] = 8'hA3;
    p[8*8'hF0 +: 8] = 8'h5A; p[8*8'hF1 +: 8] = 8'hF0; p[8*8'hF2 +: 8] = 8'hF1;
    p[8*8'hF4 +: 8] = 8'h50; p[8*8'hF5 +: 8] = 8'h60; p[8*8'hF6 +: 8] = 8'hF5;
    return p;
  endfunction

  localparam logic [2047:0] IMAGE = build_image();

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dbg_pc, dbg_ir;
  logic [31:0] dbg_regs;
  logic        dbg_carry, dbg_neg, dbg_fetch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mc8_core #(.MEM_INIT(IMAGE)) u_dut (
    .clk, .rst_n, .dbg_pc, .dbg_ir, .dbg_regs, .dbg_carry, .dbg_neg, .dbg_fetch
  );

  // behavioural reference: instruction-level model with per-instruction length
  int m_mem [256];
  int m_r   [4];
  int m_pc, m_ir, m_c, m_n;

  function automatic int deref(input int start, input int levels);
    int v = start;
    for (int k = 0; k < levels; k++) v = m_mem[v];
    return v;
  endfunction

  task automatic exec_one(output int len, output string tag);
    int ins, op, d, s, a, b, t, res, mm, kind, second, adr;
    ins  = m_mem[m_pc];
    m_ir = ins;
    m_pc = (m_pc + 1) % 256;
    if (ins < 128) begin
      op = (ins / 16) % 8; d = (ins / 4) % 4; s = ins % 4;
      a = m_r[d]; b = m_r[s]; len = 5;
      tag = (op == 4) ? "R3" : "R2";
      case (op)
        0: begin res = b; m_c = 0; end
        1: begin t = a + b; res = t % 256; m_c = (t > 255); end
        2: begin t = a + b + m_c; res = t % 256; m_c = (t > 255); end
        3, 4: begin res = (a - b + 256) % 256; m_c = (a < b); end
        5: begin res = a & b; m_c = 0; end
        6: begin res = a | b; m_c = 0; end
        default: begin res = a ^ b; m_c = 0; end
      endcase
      m_n = (res >= 128);
      if (op != 4) m_r[d] = res;
    end else if (ins < 160) begin
      op = (ins / 4) % 8; d = ins % 4; a = m_r[d]; len = 5; tag = "R4";
      case (op)
        0: begin res = (a + 1) % 256; m_c = (a == 255); end
        1: begin res = (a + 255) % 256; m_c = (a == 0); end
        2: begin res = 0; m_c = 0; end
        3: begin res = 255 - a; m_c = 0; end
        4: begin res = (a / 2) + (a & 128); m_c = a % 2; end
        5: begin res = a / 2; m_c = a % 2; end
        6: begin res = (a * 2) % 256; m_c = (a >= 128); end
        default: begin res = (a * 2) % 256 + m_c; m_c = (a >= 128); end
      endcase
      m_n = (res >= 128);
      m_r[d] = res;
    end else if (ins < 168) begin
      m_pc = m_r[ins % 4]; len = 5; tag = "R5";
    end else if (ins < 176) begin
      tag = "R10";
      case (ins % 4)
        0: t = 1;
        1: t = m_c;
        2: t = !m_c;
        default: t = m_n;
      endcase
      if (t != 0) begin m_pc = (m_pc + 2) % 256; len = 5; end
      else len = 4;
    end else if (ins < 192) begin
      len = 3; tag = "R11";
    end else begin
      kind = (ins / 16) % 4; mm = (ins / 4) % 4; d = ins % 4;
      second = m_pc;
      m_pc = (m_pc + 1) % 256;
      case (kind)
        0: begin m_r[d] = deref(m_mem[second], mm); len = 6 + 2*mm; tag = "R6"; end
        1: begin
          adr = (mm == 0) ? second : deref(m_mem[second], mm - 1);
          m_mem[adr] = m_r[d];
          len = (mm == 0) ? 5 : 5 + 2*mm; tag = "R7";
        end
        2: begin m_pc = deref(m_mem[second], mm); len = 6 + 2*mm; tag = "R8"; end
        default: begin
          m_r[d] = m_pc;
          m_pc = deref(m_mem[second], mm); len = 7 + 2*mm; tag = "R9";
        end
      endcase
    end
  endtask

  task automatic check_state(input string tag);
    logic [31:0] exp_regs;
    exp_regs = {m_r[3][7:0], m_r[2][7:0], m_r[1][7:0], m_r[0][7:0]};
    checks++;
    if (dbg_pc !== m_pc[7:0] || dbg_regs !== exp_regs || dbg_ir !== m_ir[7:0] ||
        dbg_carry !== m_c[0] || dbg_neg !== m_n[0]) begin
      errors++;
      $display("FAIL %s: pc=%h ir=%h regs=%h c=%b n=%b, expected pc=%h ir=%h regs=%h c=%b n=%b",
               tag, dbg_pc, dbg_ir, dbg_regs, dbg_carry, dbg_neg,
               m_pc[7:0], m_ir[7:0], exp_regs, m_c[0], m_n[0]);
    end
  endtask

  task automatic check_fetch(input logic exp);
    checks++;
    if (dbg_fetch !== exp) begin
      errors++;
      $display("FAIL R1: dbg_fetch=%b expected %b at pc=%h", dbg_fetch, exp, dbg_pc);
    end
  endtask

  initial begin
    int remaining, len, executed;
    string tag;
    for (int i = 0; i < 256; i++) m_mem[i] = int'(IMAGE[8*i +: 8]);
    for (int i = 0; i < 4; i++) m_r[i] = 0;
    m_pc = 0; m_ir = 0; m_c = 0; m_n = 0;
    remaining = 0; executed = 0;
    tag = "R12";   // first boundary checks the reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      if (remaining == 0) begin
        check_fetch(1'b1);
        check_state(tag);
        if (executed == NINSTR) break;
        exec_one(len, tag);
        remaining = len - 1;
        executed++;
      end else begin
        check_fetch(1'b0);
        remaining--;
      end
      @(negedge clk);
    end
    if (executed != NINSTR) begin
      errors++;
      checks++;
      $display("FAIL R1: only %0d instructions completed, expected %0d", executed, NINSTR);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired, actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule